// File: doc/BRIEF.md
# Byte-Serial Word Swap Register

This block keeps a single stored word and trades it for a new one. A transaction opens when the input valid strobe is high while the block is idle. The byte presented in that cycle and the bytes in the next three cycles form the new word. The block then copies the current stored word aside and writes the new word into storage. Over four further cycles it returns the copied word one byte per cycle, together with its own valid strobe.

Every transaction follows the same schedule, which never changes. A caller therefore knows, from the cycle in which it raised the strobe, the exact cycle in which each returned byte appears. The value returned is always the contents from before the write. Two transactions in a row therefore act as a one-word exchange: the second returns what the first stored.

Top module: `byte_swap_reg`

## Requirements
- R1: While reset is asserted and after it is released, the output valid strobe is low, the output bus reads zero, the block is idle, and the stored word is zero (the first transaction after reset returns 0x00000000).
- R2: A transaction starts in a cycle where the block is idle and the input strobe is high. The input bus is sampled in that cycle (cycle 0) and in cycles 1, 2 and 3, whatever the strobe does in cycles 1 to 3. The byte from cycle k lands at bits [8k+7:8k] of the new word.
- R3: The output valid strobe stays low in cycles 0 to 5: the four input cycles, the capture cycle (4) and the storage write cycle (5). It rises in cycle 6.
- R4: The output valid strobe stays high for exactly four consecutive cycles (cycles 6 to 9) and is low in cycle 10.
- R5: In cycle 6+k the output bus carries bits [8k+7:8k] of the returned word, so the least significant byte comes first.
- R6: The returned word is the stored word from before this transaction's write. The new word becomes the stored word and is what the next transaction returns.
- R7: A high input strobe during cycles 1 to 9 of a transaction does not start another transaction. If the strobe is low from cycle 10 on, the output valid strobe stays low.
- R8: A strobe in cycle 10, the first cycle after the output valid strobe drops, starts the next transaction.
- R9: Whenever the output valid strobe is low, the output bus is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Starts a transaction when the block is idle |
| in_byte | input | LANE_W (8) | Incoming byte stream |
| out_vld | output | 1 | High while returned bytes are on out_byte |
| out_byte | output | LANE_W (8) | Returned byte stream, zero when out_vld is low |

## Verification
The bench builds the block with its defaults: 8-bit lanes and four lanes per word. With these values the whole ten-cycle schedule fits in a short run, so every cycle of it can be sampled and checked by hand-derived expectations. A table of words is pushed back to back, which exercises the start in cycle 10 and the exchange of old and new contents on every pass. Directed runs hold the strobe high through a whole transaction and cut a transaction short with reset.

// File: rtl/byte_swap_reg.sv
module byte_swap_reg #(
  parameter int LANE_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [LANE_W-1:0] in_byte,
  output logic              out_vld,
  output logic [LANE_W-1:0] out_byte
);
  localparam int WORD_W = LANE_W * LANES;
  localparam int IDX_W  = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LANES - 1);

  typedef enum logic [2:0] {S_IDLE, S_GATHER, S_READ, S_WRITE, S_SEND} st_t;

  st_t               st;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] asm_w;
  logic [WORD_W-1:0] store;
  logic [WORD_W-1:0] old_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      idx   <= '0;
      asm_w <= '0;
      store <= '0;
      old_w <= '0;
    end else begin
      case (st)
        S_IDLE: if (in_vld) begin
          asm_w <= {{(WORD_W-LANE_W){1'b0}}, in_byte};
          idx   <= (LANES > 1) ? IDX_W'(1) : '0;
          st    <= (LANES > 1) ? S_GATHER : S_READ;
        end
        S_GATHER: begin
          asm_w[idx*LANE_W +: LANE_W] <= in_byte;
          if (idx == LAST) begin
            idx <= '0;
            st  <= S_READ;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_READ: begin
          old_w <= store;
          st    <= S_WRITE;
        end
        S_WRITE: begin
          store <= asm_w;
          idx   <= '0;
          st    <= S_SEND;
        end
        S_SEND: begin
          if (idx == LAST) begin
            idx <= '0;
            st  <= S_IDLE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign out_vld  = (st == S_SEND);
  assign out_byte = out_vld ? old_w[idx*LANE_W +: LANE_W] : '0;
endmodule

// File: rtl/byte_swap_reg_chk.sv
module byte_swap_reg_chk #(
  parameter int LANE_W = 8,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_vld,
  input logic              out_vld,
  input logic [LANE_W-1:0] out_byte
);
  logic [7:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !out_vld) run_q <= '0;
    else if (run_q != 8'hff) run_q <= run_q + 1'b1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!out_vld && out_byte == '0));

  assert_run_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (run_q < 8'(LANES)));

  assert_run_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_vld) |-> ($past(run_q) == 8'(LANES - 1)));

  assert_start_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_vld) |-> $past(in_vld, 6));

  assert_idle_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> (out_byte == '0));
endmodule

bind byte_swap_reg byte_swap_reg_chk #(.LANE_W(LANE_W), .LANES(LANES)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .out_vld(out_vld), .out_byte(out_byte)
);

// File: tb/byte_swap_reg_tb_top.sv
module byte_swap_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_vld = 1'b0;
  logic [7:0] in_byte = '0;
  logic       out_vld;
  logic [7:0] out_byte;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] model = '0;

  always #10 clk = ~clk;

  byte_swap_reg dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_byte(in_byte),
    .out_vld(out_vld), .out_byte(out_byte)
  );

  localparam logic [31:0] VEC [6] = '{
    32'h1234_5678, 32'hDEAD_BEEF, 32'h0000_0000,
    32'hFFFF_FFFF, 32'h8000_0001, 32'hA5C3_3C5A
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // Entered at a negedge with the block idle; leaves at the negedge of cycle 10.
  task automatic swap(input logic [31:0] w, input bit hold);
    for (int k = 0; k < 4; k++) begin
      in_vld  = (k == 0) || hold;
      in_byte = w[8*k +: 8];
      check({31'd0, out_vld}, 32'd0, "R3 low in input cycle");
      @(negedge clk);
    end
    in_byte = 8'h00;
    in_vld  = hold;
    check({31'd0, out_vld}, 32'd0, "R3 low in capture cycle");
    @(negedge clk);
    check({31'd0, out_vld}, 32'd0, "R3 low in write cycle");
    check({24'd0, out_byte}, 32'd0, "R9 bus zero while invalid");
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      check({31'd0, out_vld}, 32'd1, "R4 valid high in output cycle");
      check({24'd0, out_byte}, {24'd0, model[8*k +: 8]}, "R5 R6 returned byte");
      @(negedge clk);
    end
    in_vld = 1'b0;
    check({31'd0, out_vld}, 32'd0, "R4 valid low in cycle 10");
    check({24'd0, out_byte}, 32'd0, "R9 bus zero after run");
    model = w;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    check({31'd0, out_vld}, 32'd0, "R1 valid low in reset");
    check({24'd0, out_byte}, 32'd0, "R1 bus zero in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check({31'd0, out_vld}, 32'd0, "R1 idle after reset");

    // table walk, back to back starts in cycle 10 (R8); first returns reset value (R1)
    foreach (VEC[i]) swap(VEC[i], 1'b0);

    // R7: strobe held high through cycles 1..9 starts nothing
    swap(32'h0BAD_F00D, 1'b1);
    for (int c = 0; c < 12; c++) begin
      check({31'd0, out_vld}, 32'd0, "R7 no extra transaction");
      @(negedge clk);
    end
    swap(32'h1357_9BDF, 1'b0);

    // R2: strobe only in cycle 0, byte order checked by the next return
    swap(32'h0403_0201, 1'b0);
    swap(32'h0, 1'b0);

    // R1: reset in the middle of a transaction
    in_vld = 1'b1; in_byte = 8'h77;
    @(negedge clk);
    in_vld = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check({31'd0, out_vld}, 32'd0, "R1 valid low after mid reset");
    check({24'd0, out_byte}, 32'd0, "R1 bus zero after mid reset");
    model = '0;
    swap(32'hCAFE_0001, 1'b0);
    swap(32'h0, 1'b0);
    report();
  end
endmodule